// File: doc/BRIEF.md
# Coprocessor register hazard and forwarding unit

This block holds the floating-point coprocessor's register file. Around it sit a per-register pending-result scoreboard, the address comparators that find read-after-write hazards, and the bypass multiplexers that resolve them. It serves three requesters: the host CPU write port, which commits from the CPU writeback stage; the host CPU read port; and the coprocessor's operand-fetch stage, which reads two source operands. It also accepts result writebacks from the coprocessor execution pipeline.

A register is marked pending when an instruction that names it as destination leaves the operand-fetch stage. The mark is cleared by the execution writeback for that register.
- A host read of a pending register is stalled.
- An operand-fetch instruction that sources a pending register is held.
- A host write that targets a source of an operand-fetch instruction is bypassed straight into that operand, but only while the instruction is in its first cycle in the stage. Once the instruction has waited there, the bypass is switched off and the host write is held until the instruction dispatches. Older instructions therefore never see younger data.
- A host write and a host read of the same register in the same cycle return the write data. This is the cycle the CPU's own inserted stall produces.

Top module: `fcop_regs_hazard`

## Requirements
- R1: After reset, every register reads as zero, no register is pending, and no stall output is asserted.
- R2: A dispatch with `op_dst_en` high marks register `op_dst` pending from the next cycle. A valid execution writeback clears the pending mark of `xw_addr` from the next cycle. When both name the same register in one cycle, the register ends up pending.
- R3: A host read of a pending register asserts `cr_stall`. In the cycle after the execution writeback for that register, the stall is gone and `cr_data` returns the written-back value.
- R4: An operand-fetch instruction whose non-bypassed source is pending asserts `op_stall` and holds `op_dispatch` low. Otherwise `op_dispatch` equals `op_valid`.
- R5: In the first cycle an instruction spends in operand fetch, a committing host write whose address equals a source address appears on that operand output in the same cycle. That source then does not cause a stall, even if it is pending.
- R6: A host write and a host read of the same address in the same cycle put the write data on `cr_data` in that cycle, with no stall.
- R7: When the operand-fetch instruction has already spent at least one earlier cycle in the stage, a host write matching one of its sources is not bypassed. The operand shows the register-file value, and `cw_stall` is asserted.
- R8: A held host write stays held through the dispatch cycle of the waiting instruction. It commits in the first cycle in which no matching waited instruction remains.
- R9: Register address 0 is an ordinary register: it is written, read and bypassed like any other.
- R10: A committing host write takes effect at the clock edge. Other addresses read in that cycle return their old values, and the written value is read from the next cycle on.
- R11: An execution writeback updates the register file at the clock edge. If a committing host write targets the same address in the same cycle, the host data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cw_valid | input | 1 | Host write request at the CPU writeback stage |
| cw_addr | input | 4 | Host write register address |
| cw_data | input | 32 | Host write data |
| cw_stall | output | 1 | Host write held this cycle |
| cr_valid | input | 1 | Host read request |
| cr_addr | input | 4 | Host read register address |
| cr_data | output | 32 | Host read data (bypassed when applicable) |
| cr_stall | output | 1 | Host read must stall |
| op_valid | input | 1 | Operand-fetch stage holds an instruction |
| op_src0 | input | 4 | First source register |
| op_src1 | input | 4 | Second source register |
| op_dst | input | 4 | Destination register |
| op_dst_en | input | 1 | Instruction writes a destination |
| op_data0 | output | 32 | First operand value |
| op_data1 | output | 32 | Second operand value |
| op_stall | output | 1 | Operand-fetch instruction held |
| op_dispatch | output | 1 | Instruction leaves operand fetch this cycle |
| xw_valid | input | 1 | Execution result writeback |
| xw_addr | input | 4 | Writeback register address |
| xw_data | input | 32 | Writeback data |

## Verification
Host write and read patterns are driven both at the same address and at different addresses. This separates the same-cycle read bypass from the edge-timed register update. Operand-fetch instructions are presented fresh and after waiting, each with a matching host write. This separates the bypass path from the held-write path and confirms the write lands only after dispatch. Pending marks are set, cleared, and set and cleared together. Comparing read stalls with operand stalls then tells the scoreboard's priority apart from the register file's own write priority between host and execution data.

// File: rtl/fcop_pkg.sv
package fcop_pkg;
  parameter int unsigned NUM_REGS   = 16;
  parameter int unsigned DATA_WIDTH = 32;
  parameter int unsigned ADDR_WIDTH = $clog2(NUM_REGS);
endpackage

// File: rtl/fcop_regfile.sv
module fcop_regfile #(
  parameter int unsigned NREG = fcop_pkg::NUM_REGS,
  parameter int unsigned DW   = fcop_pkg::DATA_WIDTH,
  parameter int unsigned AW   = fcop_pkg::ADDR_WIDTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_data,
  input  logic          exe_we,
  input  logic [AW-1:0] exe_addr,
  input  logic [DW-1:0] exe_data,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  logic [DW-1:0] mem_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          hit_host;
    logic          hit_exe;
    logic          reg_en;
    logic [DW-1:0] reg_d;

    always_comb begin
      hit_host = host_we && (host_addr == AW'(g));
      hit_exe  = exe_we  && (exe_addr  == AW'(g));
      reg_en   = hit_host || hit_exe;
      reg_d    = hit_host ? host_data : exe_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (reg_en) begin
        mem_q[g] <= reg_d;
      end
    end
  end

  assign rd0 = mem_q[ra0];
  assign rd1 = mem_q[ra1];
  assign rd2 = mem_q[ra2];

  // R10 / R11: a host write is what the register holds after the edge
  p_host_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |=> mem_q[$past(host_addr)] == $past(host_data));

  // R11: an execution write without a colliding host write lands
  p_exe_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_we && !(host_we && host_addr == exe_addr)) |=> mem_q[$past(exe_addr)] == $past(exe_data));
endmodule

// File: rtl/fcop_scoreboard.sv
module fcop_scoreboard #(
  parameter int unsigned NREG = fcop_pkg::NUM_REGS,
  parameter int unsigned AW   = fcop_pkg::ADDR_WIDTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [AW-1:0]   set_addr,
  input  logic            clr_en,
  input  logic [AW-1:0]   clr_addr,
  output logic [NREG-1:0] pending
);
  logic [NREG-1:0] pend_q;
  logic [NREG-1:0] pend_d;
  logic [NREG-1:0] set_vec;
  logic [NREG-1:0] clr_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_bit
    assign set_vec[g] = set_en && (set_addr == AW'(g));
    assign clr_vec[g] = clr_en && (clr_addr == AW'(g));
  end

  always_comb begin
    pend_d = (pend_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

  // R2: a dispatch with a destination marks the register pending
  p_set_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pending[$past(set_addr)]);

  // R2: a writeback clears the mark unless a same-cycle set names the register
  p_clr_unmarks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_addr == clr_addr)) |=> !pending[$past(clr_addr)]);

  // R1: at most one new mark per cycle
  p_one_new_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pending & ~$past(pending)) <= 1);
endmodule

// File: rtl/fcop_hazard_ctl.sv
module fcop_hazard_ctl #(
  parameter int unsigned NREG = fcop_pkg::NUM_REGS,
  parameter int unsigned DW   = fcop_pkg::DATA_WIDTH,
  parameter int unsigned AW   = fcop_pkg::ADDR_WIDTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] pending,
  input  logic            cw_valid,
  input  logic [AW-1:0]   cw_addr,
  input  logic [DW-1:0]   cw_data,
  input  logic            cr_valid,
  input  logic [AW-1:0]   cr_addr,
  input  logic            op_valid,
  input  logic [AW-1:0]   op_src0,
  input  logic [AW-1:0]   op_src1,
  input  logic            op_dst_en,
  input  logic [DW-1:0]   rf_src0,
  input  logic [DW-1:0]   rf_src1,
  input  logic [DW-1:0]   rf_rd,
  output logic            cw_commit,
  output logic            cw_stall,
  output logic [DW-1:0]   cr_data,
  output logic            cr_stall,
  output logic [DW-1:0]   op_data0,
  output logic [DW-1:0]   op_data1,
  output logic            op_stall,
  output logic            op_dispatch,
  output logic            mark_en
);
  logic waited_q;
  logic waited_d;
  logic hit0;
  logic hit1;
  logic byp0;
  logic byp1;
  logic byp_rd;
  logic hold0;
  logic hold1;

  always_comb begin
    hit0      = op_valid && cw_valid && (cw_addr == op_src0);
    hit1      = op_valid && cw_valid && (cw_addr == op_src1);
    cw_stall  = waited_q && (hit0 || hit1);
    cw_commit = cw_valid && !cw_stall;
    byp0      = hit0 && !waited_q;
    byp1      = hit1 && !waited_q;

    hold0       = pending[op_src0] && !byp0;
    hold1       = pending[op_src1] && !byp1;
    op_stall    = op_valid && (hold0 || hold1);
    op_dispatch = op_valid && !op_stall;
    mark_en     = op_dispatch && op_dst_en;
    op_data0    = byp0 ? cw_data : rf_src0;
    op_data1    = byp1 ? cw_data : rf_src1;

    byp_rd   = cr_valid && cw_commit && (cw_addr == cr_addr);
    cr_stall = cr_valid && pending[cr_addr] && !byp_rd;
    cr_data  = byp_rd ? cw_data : rf_rd;

    waited_d = op_valid && !op_dispatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waited_q <= 1'b0;
    end else begin
      waited_q <= waited_d;
    end
  end

  // R7: the waited flag only follows a cycle in which an instruction stayed
  p_waited_follows_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    waited_q |-> ($past(op_valid) && !$past(op_dispatch)));

  // R7: a held host write never reaches an operand output
  p_no_bypass_when_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_stall && op_src0 == cw_addr) |-> op_data0 == rf_src0);

  // R8: a held write always has a waiting instruction in front of it
  p_hold_needs_waiter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cw_stall |-> (op_valid && $past(op_valid)));

  // R4: nothing dispatches with a non-bypassed pending source
  p_no_dispatch_on_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_dispatch |-> !(pending[op_src0] && op_data0 == rf_src0 && !(cw_commit && cw_addr == op_src0 && !waited_q)));
endmodule

// File: rtl/fcop_regs_hazard.sv
module fcop_regs_hazard #(
  parameter int unsigned NREG = fcop_pkg::NUM_REGS,
  parameter int unsigned DW   = fcop_pkg::DATA_WIDTH,
  parameter int unsigned AW   = fcop_pkg::ADDR_WIDTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_valid,
  input  logic [AW-1:0] cw_addr,
  input  logic [DW-1:0] cw_data,
  output logic          cw_stall,
  input  logic          cr_valid,
  input  logic [AW-1:0] cr_addr,
  output logic [DW-1:0] cr_data,
  output logic          cr_stall,
  input  logic          op_valid,
  input  logic [AW-1:0] op_src0,
  input  logic [AW-1:0] op_src1,
  input  logic [AW-1:0] op_dst,
  input  logic          op_dst_en,
  output logic [DW-1:0] op_data0,
  output logic [DW-1:0] op_data1,
  output logic          op_stall,
  output logic          op_dispatch,
  input  logic          xw_valid,
  input  logic [AW-1:0] xw_addr,
  input  logic [DW-1:0] xw_data
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NREG-1:0] pending;
  logic [DW-1:0]   rf_src0;
  logic [DW-1:0]   rf_src1;
  logic [DW-1:0]   rf_rd;
  logic            cw_commit;
  logic            mark_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  fcop_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) i_regfile (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .host_we   (cw_commit),
    .host_addr (cw_addr),
    .host_data (cw_data),
    .exe_we    (xw_valid),
    .exe_addr  (xw_addr),
    .exe_data  (xw_data),
    .ra0       (op_src0),
    .ra1       (op_src1),
    .ra2       (cr_addr),
    .rd0       (rf_src0),
    .rd1       (rf_src1),
    .rd2       (rf_rd)
  );

  fcop_scoreboard #(.NREG(NREG), .AW(AW)) i_scoreboard (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_en   (mark_en),
    .set_addr (op_dst),
    .clr_en   (xw_valid),
    .clr_addr (xw_addr),
    .pending  (pending)
  );

  fcop_hazard_ctl #(.NREG(NREG), .DW(DW), .AW(AW)) i_hazard_ctl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .pending     (pending),
    .cw_valid    (cw_valid),
    .cw_addr     (cw_addr),
    .cw_data     (cw_data),
    .cr_valid    (cr_valid),
    .cr_addr     (cr_addr),
    .op_valid    (op_valid),
    .op_src0     (op_src0),
    .op_src1     (op_src1),
    .op_dst_en   (op_dst_en),
    .rf_src0     (rf_src0),
    .rf_src1     (rf_src1),
    .rf_rd       (rf_rd),
    .cw_commit   (cw_commit),
    .cw_stall    (cw_stall),
    .cr_data     (cr_data),
    .cr_stall    (cr_stall),
    .op_data0    (op_data0),
    .op_data1    (op_data1),
    .op_stall    (op_stall),
    .op_dispatch (op_dispatch),
    .mark_en     (mark_en)
  );

  // R3: a host read stall always names a register the scoreboard holds
  p_read_stall_pending_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    cr_stall |-> pending[cr_addr]);

  // R6: same-address host write and read return the write data
  p_read_bypass_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cr_valid && cw_valid && !cw_stall && cw_addr == cr_addr) |-> (cr_data == cw_data && !cr_stall));
endmodule

// File: tb/test_fcop_regs_hazard.sv
module test_fcop_regs_hazard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cw_valid;
  logic [3:0]  cw_addr;
  logic [31:0] cw_data;
  logic        cw_stall;
  logic        cr_valid;
  logic [3:0]  cr_addr;
  logic [31:0] cr_data;
  logic        cr_stall;
  logic        op_valid;
  logic [3:0]  op_src0;
  logic [3:0]  op_src1;
  logic [3:0]  op_dst;
  logic        op_dst_en;
  logic [31:0] op_data0;
  logic [31:0] op_data1;
  logic        op_stall;
  logic        op_dispatch;
  logic        xw_valid;
  logic [3:0]  xw_addr;
  logic [31:0] xw_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fcop_regs_hazard i_fcop_regs_hazard (
    .clk(clk), .rst_n(rst_n),
    .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data), .cw_stall(cw_stall),
    .cr_valid(cr_valid), .cr_addr(cr_addr), .cr_data(cr_data), .cr_stall(cr_stall),
    .op_valid(op_valid), .op_src0(op_src0), .op_src1(op_src1), .op_dst(op_dst),
    .op_dst_en(op_dst_en), .op_data0(op_data0), .op_data1(op_data1),
    .op_stall(op_stall), .op_dispatch(op_dispatch),
    .xw_valid(xw_valid), .xw_addr(xw_addr), .xw_data(xw_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cw_valid = 0; cw_addr = 0; cw_data = 0;
    cr_valid = 0; cr_addr = 0;
    op_valid = 0; op_src0 = 0; op_src1 = 0; op_dst = 0; op_dst_en = 0;
    xw_valid = 0; xw_addr = 0; xw_data = 0;
  endtask

  // start a cycle: inputs change at the falling edge, outputs read 2 ns later
  task automatic cyc_begin();
    @(negedge clk);
    idle();
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 16; a += 5) begin
      cyc_begin(); cr_valid = 1; cr_addr = 4'(a); settle();
      chk("R1 reset read data", cr_data, 32'h0);
      chk("R1 reset read stall", {31'b0, cr_stall}, 32'h0);
    end
    cyc_begin(); op_valid = 1; op_src0 = 4'd3; op_src1 = 4'd15; settle();
    chk("R1 reset no operand stall", {31'b0, op_stall}, 32'h0);
    chk("R1 reset host write not held", {31'b0, cw_stall}, 32'h0);
  endtask

  task automatic t_write_timing();
    cyc_begin(); cw_valid = 1; cw_addr = 4'd5; cw_data = 32'hA5A5_0001;
    cr_valid = 1; cr_addr = 4'd6; settle();
    chk("R10 other address old value", cr_data, 32'h0);
    cyc_begin(); cr_valid = 1; cr_addr = 4'd5; settle();
    chk("R10 write visible next cycle", cr_data, 32'hA5A5_0001);
  endtask

  task automatic t_read_bypass();
    cyc_begin(); cw_valid = 1; cw_addr = 4'd7; cw_data = 32'hB0B0_0007;
    cr_valid = 1; cr_addr = 4'd7; settle();
    chk("R6 same-cycle read bypass", cr_data, 32'hB0B0_0007);
    cyc_begin(); cw_valid = 1; cw_addr = 4'd0; cw_data = 32'h0000_C0DE;
    cr_valid = 1; cr_addr = 4'd0; settle();
    chk("R9 address 0 read bypass", cr_data, 32'h0000_C0DE);
    cyc_begin(); cr_valid = 1; cr_addr = 4'd0; settle();
    chk("R9 address 0 stored", cr_data, 32'h0000_C0DE);
  endtask

  task automatic t_pending();
    cyc_begin(); op_valid = 1; op_src0 = 4'd1; op_src1 = 4'd2; op_dst = 4'd3; op_dst_en = 1; settle();
    chk("R4 free sources dispatch", {31'b0, op_dispatch}, 32'h1);
    cyc_begin(); cr_valid = 1; cr_addr = 4'd3; op_valid = 1; op_src0 = 4'd3; op_src1 = 4'd1; settle();
    chk("R3 read of pending stalls", {31'b0, cr_stall}, 32'h1);
    chk("R4 pending source holds", {30'b0, op_stall, op_dispatch}, 32'h2);
    cyc_begin(); cr_valid = 1; cr_addr = 4'd3; xw_valid = 1; xw_addr = 4'd3; xw_data = 32'h1234_5678; settle();
    chk("R2 still pending in writeback cycle", {31'b0, cr_stall}, 32'h1);
    cyc_begin(); cr_valid = 1; cr_addr = 4'd3; settle();
    chk("R3 stall released after writeback", {31'b0, cr_stall}, 32'h0);
    chk("R3 written-back value read", cr_data, 32'h1234_5678);
    cyc_begin(); op_valid = 1; op_src0 = 4'd1; op_src1 = 4'd1; op_dst = 4'd4; op_dst_en = 1;
    xw_valid = 1; xw_addr = 4'd4; xw_data = 32'h4444; settle();
    cyc_begin(); cr_valid = 1; cr_addr = 4'd4; settle();
    chk("R2 set wins over clear", {31'b0, cr_stall}, 32'h1);
    cyc_begin(); xw_valid = 1; xw_addr = 4'd4; xw_data = 32'h4545; settle();
    cyc_begin(); cr_valid = 1; cr_addr = 4'd4; settle();
    chk("R2 later clear frees register", {31'b0, cr_stall}, 32'h0);
  endtask

  task automatic t_op_bypass();
    cyc_begin(); op_valid = 1; op_src0 = 4'd9; op_src1 = 4'd9;
    cw_valid = 1; cw_addr = 4'd9; cw_data = 32'hD00D_0009; settle();
    chk("R5 operand0 bypass", op_data0, 32'hD00D_0009);
    chk("R5 operand1 bypass", op_data1, 32'hD00D_0009);
    chk("R5 bypassed instruction dispatches", {31'b0, op_dispatch}, 32'h1);
    cyc_begin(); op_valid = 1; op_src0 = 4'd1; op_src1 = 4'd1; op_dst = 4'd8; op_dst_en = 1; settle();
    cyc_begin(); settle();
    cyc_begin(); op_valid = 1; op_src0 = 4'd8; op_src1 = 4'd0;
    cw_valid = 1; cw_addr = 4'd8; cw_data = 32'h8888_0008; settle();
    chk("R5 bypass covers pending source", {31'b0, op_dispatch}, 32'h1);
    chk("R5 bypass value on pending source", op_data0, 32'h8888_0008);
    cyc_begin(); op_valid = 1; op_src0 = 4'd2; op_src1 = 4'd0;
    cw_valid = 1; cw_addr = 4'd0; cw_data = 32'h0000_0F0F; settle();
    chk("R9 address 0 operand bypass", op_data1, 32'h0000_0F0F);
    cyc_begin(); xw_valid = 1; xw_addr = 4'd8; xw_data = 32'h0; settle();
  endtask

  task automatic t_held_write();
    cyc_begin(); op_valid = 1; op_src0 = 4'd1; op_src1 = 4'd1; op_dst = 4'd10; op_dst_en = 1; settle();
    cyc_begin(); op_valid = 1; op_src0 = 4'd10; op_src1 = 4'd11; settle();
    chk("R4 waits on pending source", {31'b0, op_stall}, 32'h1);
    cyc_begin(); op_valid = 1; op_src0 = 4'd10; op_src1 = 4'd11;
    cw_valid = 1; cw_addr = 4'd11; cw_data = 32'hEEEE_0011; settle();
    chk("R7 held write on waited instruction", {31'b0, cw_stall}, 32'h1);
    chk("R7 operand keeps register value", op_data1, 32'h0);
    cyc_begin(); op_valid = 1; op_src0 = 4'd10; op_src1 = 4'd11;
    cw_valid = 1; cw_addr = 4'd11; cw_data = 32'hEEEE_0011;
    xw_valid = 1; xw_addr = 4'd10; xw_data = 32'hF0F0_0010; settle();
    chk("R8 still held before dispatch", {31'b0, cw_stall}, 32'h1);
    cyc_begin(); op_valid = 1; op_src0 = 4'd10; op_src1 = 4'd11;
    cw_valid = 1; cw_addr = 4'd11; cw_data = 32'hEEEE_0011; settle();
    chk("R8 instruction dispatches", {31'b0, op_dispatch}, 32'h1);
    chk("R8 held through dispatch cycle", {31'b0, cw_stall}, 32'h1);
    chk("R8 dispatch sees writeback value", op_data0, 32'hF0F0_0010);
    chk("R7 dispatch sees old register", op_data1, 32'h0);
    cyc_begin(); cw_valid = 1; cw_addr = 4'd11; cw_data = 32'hEEEE_0011; settle();
    chk("R8 write commits after dispatch", {31'b0, cw_stall}, 32'h0);
    cyc_begin(); cr_valid = 1; cr_addr = 4'd11; settle();
    chk("R8 committed value stored", cr_data, 32'hEEEE_0011);
  endtask

  task automatic t_priority();
    cyc_begin(); cw_valid = 1; cw_addr = 4'd12; cw_data = 32'h6666_0012;
    xw_valid = 1; xw_addr = 4'd12; xw_data = 32'h7777_0012; settle();
    cyc_begin(); cr_valid = 1; cr_addr = 4'd12; settle();
    chk("R11 host data wins collision", cr_data, 32'h6666_0012);
    cyc_begin(); xw_valid = 1; xw_addr = 4'd13; xw_data = 32'h1313_1313; settle();
    cyc_begin(); cr_valid = 1; cr_addr = 4'd13; settle();
    chk("R11 execution writeback stored", cr_data, 32'h1313_1313);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_timing();
    t_read_bypass();
    t_pending();
    t_op_bypass();
    t_held_write();
    t_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule